// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-mapped watchdog. A 16-bit down-counter is clocked by ticks that come from two division stages in series: a programmable 8-bit prescaler that divides the clock by P+1, then a power-of-two divider chosen from 16, 32, 64 or 128. Software keeps the system alive by writing a fresh value to the count register before the counter runs out. When a tick arrives while the count is already zero, the timer has expired. The counter then reloads from the reload register, and the block fires an interrupt pulse, a fixed-length reset request, or both, as the control bits select.

A sticky status bit records that the block has requested a reset. It sits on its own power-on reset input, so it survives the system reset that the watchdog itself causes. Boot code can read it and then clear it by writing one. The bus is a plain single-cycle register port. Writes take effect at the clock edge that samples them. Read data is combinational on the address.

Top module: `wdog_timer`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (reload), 0x08 (count) and 0x0C (status). A read of any other offset returns zero, and a write to any other offset changes nothing.
- R2: Control fields: bit 0 enables the reset request, bit 2 enables the interrupt, bits 4:3 select the divider (0 gives /16, 1 gives /32, 2 gives /64, 3 gives /128), bit 5 starts the timer, and bits 15:8 hold the prescale value P. All other control bits read as zero.
- R3: After reset, control reads 0x0000_8019 (P=0x80, /128, reset request enabled, timer stopped). Reload and count both read 0x8000, status reads 0, and both outputs are low.
- R4: While the timer runs, the counter takes one tick every (P+1)·16·2^sel clocks, and each tick lowers a non-zero count by one.
- R5: A tick that finds the count at zero is an expiry: the count is reloaded from the reload register. If count N is in place when the timer starts, expiry happens N+1 ticks after the control write.
- R6: On expiry with the interrupt enabled, irq_o is high for exactly one clock, in the cycle after the expiring edge. It stays low when the interrupt is disabled.
- R7: On expiry with the reset request enabled, wdt_rst_o is high for exactly 4 clocks, starting in the cycle after the expiring edge.
- R8: A write to the count register loads its low 16 bits into the counter at that edge, taking priority over a tick at the same edge.
- R9: With bit 5 clear, the counter and the division stages are halted, and the count and reload values are kept.
- R10: Status bit 0 is set whenever the block starts a reset request. Writing 1 to it clears it. It is cleared by por_ni but not by rst_ni.
- R11: Any write to the control register restarts the prescaler and divider phase at zero, so the first tick comes a full tick period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low system reset for everything except the status flag |
| por_ni | input | 1 | Active-low power-on reset for the status flag |
| bus_wr_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | One-clock interrupt pulse on expiry |
| wdt_rst_o | output | 1 | Reset request held for 4 clocks on expiry |

## Verification
Some rules are checked by the assertions on every cycle. These are: the interrupt lasts a single clock and only follows an enabled expiry; the reset request never runs past its four-clock count once it has risen; a count write is visible on the next cycle; a stopped timer produces no ticks and keeps its count; and the status flag follows every reset request. Other behaviour can only be shown by the bench scenarios. That covers the exact expiry cycle for different prescale and divider settings, the phase restart on a rewrite of the control register, the reset values, the decode of unmapped offsets, and the survival of the status flag across a system reset. For these, the bench predicts each interrupt and reset cycle and compares it with what the block produces.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 8;
    localparam int CNT_W        = 16;
    localparam int PRE_W        = 8;
    localparam int SEL_W        = 2;
    localparam int DIV_LOG2_MIN = 4;
    localparam int DIV_W        = DIV_LOG2_MIN + (1 << SEL_W) - 1;
    localparam int RST_LEN      = 4;
    localparam int RST_CW       = $clog2(RST_LEN + 1);

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h0C;

    localparam int RSTEN_BIT = 0;
    localparam int IRQEN_BIT = 2;
    localparam int SEL_LSB   = 3;
    localparam int RUN_BIT   = 5;
    localparam int PRE_LSB   = 8;

    localparam logic [PRE_W-1:0] PRE_INIT   = 8'h80;
    localparam logic [SEL_W-1:0] SEL_INIT   = 2'd3;
    localparam logic [CNT_W-1:0] COUNT_INIT = 16'h8000;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic             run;
        logic [SEL_W-1:0] sel;
        logic             irq_en;
        logic             rst_en;
    } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              por_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cause_set_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              ctrl_wr_o,
    output logic              cnt_wr_o,
    output logic [CNT_W-1:0]  cnt_wdata_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  cause_d, cause_q;
    logic  stat_wr;

    always_comb begin
        regs_d    = regs_q;
        ctrl_wr_o = bus_wr_i && (bus_addr_i == OFS_CTRL);
        cnt_wr_o  = bus_wr_i && (bus_addr_i == OFS_COUNT);
        stat_wr   = bus_wr_i && (bus_addr_i == OFS_STAT);
        if (ctrl_wr_o) begin
            regs_d.ctrl.rst_en = bus_wdata_i[RSTEN_BIT];
            regs_d.ctrl.irq_en = bus_wdata_i[IRQEN_BIT];
            regs_d.ctrl.sel    = bus_wdata_i[SEL_LSB +: SEL_W];
            regs_d.ctrl.run    = bus_wdata_i[RUN_BIT];
            regs_d.ctrl.pre    = bus_wdata_i[PRE_LSB +: PRE_W];
        end
        if (bus_wr_i && (bus_addr_i == OFS_RELOAD)) begin
            regs_d.reload = bus_wdata_i[CNT_W-1:0];
        end
        cause_d = cause_set_i || (cause_q && !(stat_wr && bus_wdata_i[0]));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.ctrl.pre    <= PRE_INIT;
            regs_q.ctrl.run    <= 1'b0;
            regs_q.ctrl.sel    <= SEL_INIT;
            regs_q.ctrl.irq_en <= 1'b0;
            regs_q.ctrl.rst_en <= 1'b1;
            regs_q.reload      <= COUNT_INIT;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            cause_q <= 1'b0;
        end else begin
            cause_q <= cause_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            OFS_CTRL: begin
                bus_rdata_o[RSTEN_BIT]             = regs_q.ctrl.rst_en;
                bus_rdata_o[IRQEN_BIT]             = regs_q.ctrl.irq_en;
                bus_rdata_o[SEL_LSB +: SEL_W]      = regs_q.ctrl.sel;
                bus_rdata_o[RUN_BIT]               = regs_q.ctrl.run;
                bus_rdata_o[PRE_LSB +: PRE_W]      = regs_q.ctrl.pre;
            end
            OFS_RELOAD: bus_rdata_o[CNT_W-1:0] = regs_q.reload;
            OFS_COUNT:  bus_rdata_o[CNT_W-1:0] = cnt_i;
            OFS_STAT:   bus_rdata_o[0]         = cause_q;
            default:    bus_rdata_o            = '0;
        endcase
    end

    assign ctrl_o      = regs_q.ctrl;
    assign reload_o    = regs_q.reload;
    assign cnt_wdata_o = bus_wdata_i[CNT_W-1:0];

    // R10
    cause_set_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
        cause_set_i |=> cause_q);
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
    import wdog_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] pre_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre_cnt;
        logic [DIV_W-1:0] div_cnt;
    } phase_t;

    phase_t           ph_d, ph_q;
    logic             pre_hit;
    logic [DIV_W:0]   one_sh;
    logic [DIV_W-1:0] div_top;

    always_comb begin
        ph_d    = ph_q;
        one_sh  = (DIV_W+1)'(1) << (DIV_LOG2_MIN + int'(sel_i));
        div_top = DIV_W'(one_sh - 1'b1);
        pre_hit = run_i && (ph_q.pre_cnt == pre_i);
        tick_o  = pre_hit && (ph_q.div_cnt == div_top);
        if (restart_i || !run_i) begin
            ph_d = '0;
        end else if (pre_hit) begin
            ph_d.pre_cnt = '0;
            ph_d.div_cnt = tick_o ? '0 : ph_q.div_cnt + 1'b1;
        end else begin
            ph_d.pre_cnt = ph_q.pre_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ph_q <= '0;
        else         ph_q <= ph_d;
    end

    // R9
    no_tick_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> !tick_o);
    // R4
    tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             irq_en_i,
    input  logic             rst_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             rst_o,
    output logic             cause_set_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              irq;
        logic [RST_CW-1:0] rst_cnt;
    } core_t;

    core_t core_d, core_q;
    logic  expire;

    always_comb begin
        core_d      = core_q;
        expire      = tick_i && !cnt_wr_i && (core_q.cnt == '0);
        cause_set_o = expire && rst_en_i;
        if (cnt_wr_i) begin
            core_d.cnt = cnt_wdata_i;
        end else if (tick_i) begin
            core_d.cnt = (core_q.cnt == '0) ? reload_i : core_q.cnt - 1'b1;
        end
        core_d.irq = expire && irq_en_i;
        if (cause_set_o) begin
            core_d.rst_cnt = RST_CW'(RST_LEN);
        end else if (core_q.rst_cnt != '0) begin
            core_d.rst_cnt = core_q.rst_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            core_q.cnt     <= COUNT_INIT;
            core_q.irq     <= 1'b0;
            core_q.rst_cnt <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign cnt_o = core_q.cnt;
    assign irq_o = core_q.irq;
    assign rst_o = (core_q.rst_cnt != '0);

    // R6
    irq_one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);
    // R6
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(irq_en_i));
    // R7
    rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_o) |=> rst_o);
    // R7
    rst_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_q.rst_cnt <= RST_CW'(RST_LEN));
    // R8
    cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr_i |=> cnt_o == $past(cnt_wdata_i));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              por_ni,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_wdata;
    logic             ctrl_wr;
    logic             cnt_wr;
    logic             tick;
    logic             cause_set;

    wdog_regs u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .por_ni      (por_ni),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .cnt_i       (cnt),
        .cause_set_i (cause_set),
        .ctrl_o      (ctrl),
        .reload_o    (reload),
        .ctrl_wr_o   (ctrl_wr),
        .cnt_wr_o    (cnt_wr),
        .cnt_wdata_o (cnt_wdata)
    );

    wdog_tick u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (ctrl.run),
        .restart_i (ctrl_wr),
        .pre_i     (ctrl.pre),
        .sel_i     (ctrl.sel),
        .tick_o    (tick)
    );

    wdog_core u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .cnt_wr_i    (cnt_wr),
        .cnt_wdata_i (cnt_wdata),
        .reload_i    (reload),
        .irq_en_i    (ctrl.irq_en),
        .rst_en_i    (ctrl.rst_en),
        .cnt_o       (cnt),
        .irq_o       (irq_o),
        .rst_o       (wdt_rst_o),
        .cause_set_o (cause_set)
    );

    // R9
    stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl.run && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wrst;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_wr = 0;
    int irq_q[$];
    int rst_q[$];
    bit rst_prev = 1'b0;
    int rst_len  = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_timer dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .por_ni      (por_n),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq),
        .wdt_rst_o   (wrst)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        last_wr = cyc;
    endtask

    task automatic rd_now(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_now(a, exp, req);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // monitor: pops predicted event cycles as the outputs fire
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) begin
                if (irq_q.size() == 0) check(1'b0, "R6 unexpected irq", cyc, 0);
                else begin
                    int e;
                    e = irq_q.pop_front();
                    check(cyc == e, "R5/R6 irq cycle", cyc, e);
                end
            end
            if (wrst && !rst_prev) begin
                if (rst_q.size() == 0) check(1'b0, "R7 unexpected reset", cyc, 0);
                else begin
                    int e;
                    e = rst_q.pop_front();
                    check(cyc == e, "R7 reset start cycle", cyc, e);
                end
            end
            if (wrst) rst_len++;
            if (!wrst && rst_prev) begin
                check(rst_len == 4, "R7 reset length", rst_len, 4);
                rst_len = 0;
            end
        end
        rst_prev = wrst;
    end

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;

        // R3 reset state
        rd(8'h00, 32'h0000_8019, "R3 ctrl");
        rd(8'h04, 32'h0000_8000, "R3 reload");
        rd(8'h08, 32'h0000_8000, "R3 count");
        rd(8'h0C, 32'h0, "R3 status");
        check(!irq && !wrst, "R3 outputs", {irq, wrst}, 0);

        // R1 unmapped offsets
        rd(8'h10, 32'h0, "R1 unmapped read");
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0);
        rd(8'h00, 32'h0000_8019, "R1 ctrl after stray write");
        rd(8'h04, 32'h0000_8000, "R1 reload after stray write");
        rd(8'h0C, 32'h0, "R1 status after stray write");

        // R2 field readback, timer kept stopped; R9 halted count
        wr(8'h00, 32'hFFFF_FFDF);
        rd(8'h00, 32'h0000_FF1D, "R2 ctrl readback");
        repeat (50) @(negedge clk);
        rd(8'h08, 32'h0000_8000, "R9 count held while stopped");

        // R4 R5 R6: P=0, /16, irq only
        wr(8'h04, 32'd5);
        wr(8'h08, 32'd3);
        wr(8'h00, 32'h0000_0024);
        begin
            int b;
            b = last_wr;
            irq_q.push_back(b + 64);
            irq_q.push_back(b + 64 + 96);
            wait_until(b + 20);
            rd(8'h08, 32'd2, "R4 one tick after 16 clocks");
            wait_until(b + 64);
            rd(8'h08, 32'd5, "R5 reload on expiry");
            wait_until(b + 64 + 96 + 5);
        end
        rd(8'h0C, 32'h0, "R7 no reset cause when disabled");

        // R8 refresh while running
        wr(8'h08, 32'h0000_0100);
        rd_now(8'h08, 32'h0000_0100, "R8 count write");
        // R9 stop keeps values
        wr(8'h00, 32'h0000_0004);
        begin
            logic [31:0] held;
            bus_addr = 8'h08; #1; held = bus_rdata;
            repeat (200) @(negedge clk);
            rd_now(8'h08, held, "R9 count kept after stop");
            rd_now(8'h04, 32'd5, "R9 reload kept after stop");
        end

        // R4 prescaler P=2, /32
        wr(8'h08, 32'd1);
        wr(8'h00, 32'h0000_022C);
        irq_q.push_back(last_wr + 192);
        wait_until(last_wr + 200);
        wr(8'h00, 32'h0000_0004);

        // R11 phase restart with /128
        wr(8'h08, 32'd0);
        wr(8'h00, 32'h0000_003C);
        wait_until(last_wr + 100);
        wr(8'h00, 32'h0000_003C);
        irq_q.push_back(last_wr + 128);
        wait_until(last_wr + 130);
        wr(8'h00, 32'h0000_0004);
        check(irq_q.size() == 0, "R11 irq after restart", irq_q.size(), 0);

        // R7 R10 reset request and cause flag
        wr(8'h08, 32'd0);
        wr(8'h00, 32'h0000_0021);
        rst_q.push_back(last_wr + 16);
        wait_until(last_wr + 22);
        rd(8'h0C, 32'h1, "R10 cause set");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(8'h0C, 32'h1, "R10 cause survives system reset");
        rd(8'h00, 32'h0000_8019, "R3 ctrl after system reset");
        wr(8'h0C, 32'h1);
        rd(8'h0C, 32'h0, "R10 cause write-one clear");

        repeat (10) @(negedge clk);
        check(irq_q.size() == 0, "R6 all irqs seen", irq_q.size(), 0);
        check(rst_q.size() == 0, "R7 all resets seen", rst_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule